// File: doc/BRIEF.md
# Block-Length Packet Receive Buffer

This block is a small byte buffer between the serial-to-parallel stage of an asynchronous receiver and a host read port. A programmable block length groups incoming bytes into packets. The host is not given access byte by byte. The buffer first collects bytes. It then raises an active-low interrupt when a packet completes, or when its four slots fill in the middle of a longer packet. Only after that can the host read. The host must then empty the buffer completely, and the buffer accepts no new bytes until it has done so.

While a condition is pending, a byte that arrives from the shift stage is parked in a single holding register, and a stall signal tells the shift stage to wait. The parked byte moves into the buffer one cycle after the host's final read. If a second byte arrives while the holding register is still occupied and the condition is still pending, that byte is dropped and a sticky overrun flag is raised.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After synchronous reset the buffer is empty. `pkt_end`, `buf_full`, `stall` and `overrun` are 0, `irq_n` is 1 and `rd_data` is 0.
- R2: For a block length of 1 to 3, `pkt_end` rises and `irq_n` falls on the clock edge that stores the packet's last byte.
- R3: For a block length of 4 or more, `buf_full` rises and `irq_n` falls on the edge that stores the fourth byte in the buffer. If that byte is not the packet's last byte, `pkt_end` stays 0.
- R4: When the last byte of a packet longer than 4 bytes is stored, `pkt_end` rises exactly as for a short packet. At that point the buffer holds the remaining (length mod 4) bytes, or 4 bytes when the length is a multiple of 4.
- R5: When the block length is a multiple of 4, `pkt_end` and `buf_full` both rise on the edge that stores the packet's final byte.
- R6: While `pkt_end` or `buf_full` is set, `stall` is 1 and a presented byte is not stored. That byte waits in the holding register. It is stored one cycle after the draining read, and byte order is kept.
- R7: While neither flag is set, `rd_en` has no effect: `rd_data` reads 0 and no byte is removed.
- R8: While a flag is set, `rd_data` shows the oldest stored byte and each `rd_en` cycle removes it. The read that empties the buffer clears `pkt_end`, `buf_full` and the interrupt (`irq_n` back to 1).
- R9: A byte presented while the holding register is occupied and a flag is still set is discarded, and `overrun` is set. `overrun` stays set until reset.
- R10: A block length of 0 behaves as a block length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: a received byte is presented |
| in_data | input | DATA_W | Received byte |
| blk_len | input | LEN_W | Packet length in bytes (0 treated as 1) |
| rd_en | input | 1 | Host read strobe, removes the oldest byte |
| rd_data | output | DATA_W | Oldest stored byte while readable, else 0 |
| pkt_end | output | 1 | Packet-end condition pending |
| buf_full | output | 1 | Buffer-full condition pending |
| irq_n | output | 1 | Active-low interrupt, low while a condition is pending |
| stall | output | 1 | Shift stage must hold its next byte |
| overrun | output | 1 | Sticky: a byte was lost while stalled |

## Verification
The hardest state to reach is a condition that is pending while the holding register is already occupied. Only then can an overrun occur, and only then can a parked byte enter right after a drain. The stimulus completes a packet first, then presents one byte and a second byte without any host reads in between. It then drains the buffer and checks that the parked byte, and not the dropped one, re-raises the packet end.

// File: rtl/prf_pkg.sv
package prf_pkg;

    localparam int LEN_MAX_W = 16;

    typedef struct packed {
        logic pkt_end;
        logic buf_full;
    } prf_flags_t;

    // A programmed length of zero is treated as one byte.
    function automatic logic [LEN_MAX_W-1:0] eff_len(input logic [LEN_MAX_W-1:0] len);
        return (len == '0) ? LEN_MAX_W'(1) : len;
    endfunction

endpackage

// File: rtl/prf_store.sv
module prf_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     fill
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (wr) begin
                mem[wptr] <= wr_data;
                wptr      <= nxt(wptr);
            end
            if (pop)
                rptr <= nxt(rptr);
            case ({wr, pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
    import prf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             pop,
    input  logic [CW-1:0]    fill,
    input  logic [LEN_W-1:0] blk_len,
    output prf_flags_t       flags
);
    logic [LEN_MAX_W-1:0] pkt_cnt;
    logic [LEN_MAX_W-1:0] target;
    logic [LEN_MAX_W-1:0] cnt_inc;

    assign target  = eff_len(LEN_MAX_W'(blk_len));
    assign cnt_inc = pkt_cnt + LEN_MAX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_cnt <= '0;
            flags   <= '0;
        end else if (wr) begin
            if (cnt_inc >= target) begin
                flags.pkt_end <= 1'b1;
                pkt_cnt       <= '0;
            end else begin
                pkt_cnt <= cnt_inc;
            end
            if (fill == CW'(DEPTH - 1))
                flags.buf_full <= 1'b1;
        end else if (pop && fill == CW'(1)) begin
            flags <= '0;
        end
    end
endmodule

// File: rtl/prf_hold.sv
module prf_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              wr,
    output logic [DATA_W-1:0] wr_data,
    output logic              held,
    output logic              overrun
);
    logic [DATA_W-1:0] hold_q;

    assign wr      = !gate && (held || in_valid);
    assign wr_data = held ? hold_q : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= 1'b0;
            hold_q  <= '0;
            overrun <= 1'b0;
        end else if (in_valid && held && gate) begin
            overrun <= 1'b1;
        end else if (in_valid && (gate || held)) begin
            hold_q <= in_data;
            held   <= 1'b1;
        end else if (held && !gate) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import prf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              pkt_end,
    output logic              buf_full,
    output logic              irq_n,
    output logic              stall,
    output logic              overrun
);
    prf_flags_t        flags;
    logic              gate, wr, pop, held;
    logic [DATA_W-1:0] wr_data, head;
    logic [CW-1:0]     fill;

    assign gate = flags.pkt_end || flags.buf_full;
    assign pop  = rd_en && gate && (fill != '0);

    prf_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .gate(gate), .in_valid(in_valid),
        .in_data(in_data), .wr(wr), .wr_data(wr_data), .held(held),
        .overrun(overrun)
    );

    prf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .wr(wr), .wr_data(wr_data), .pop(pop),
        .head(head), .fill(fill)
    );

    prf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr(wr), .pop(pop), .fill(fill),
        .blk_len(blk_len), .flags(flags)
    );

    assign rd_data  = (gate && fill != '0) ? head : '0;
    assign pkt_end  = flags.pkt_end;
    assign buf_full = flags.buf_full;
    assign irq_n    = !gate;
    assign stall    = gate || held;
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          pkt_end,
    input logic          buf_full,
    input logic          overrun,
    input logic [CW-1:0] fill
);
    logic pend;
    assign pend = pkt_end || buf_full;

    p_no_entry_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && !rd_en) |=> fill == $past(fill));

    p_drain_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (pend && rd_en && fill == CW'(1)) |=> (!pkt_end && !buf_full));

    p_full_level_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> fill == CW'(DEPTH));

    p_no_pop_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!pend && rd_en) |=> fill >= $past(fill));

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));
endmodule

bind pkt_rx_fifo prf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .pkt_end(pkt_end),
    .buf_full(buf_full), .overrun(overrun), .fill(fill)
);

// File: tb/sim_pkt_rx_fifo.sv
module sim_pkt_rx_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [7:0] blk_len = 8'd1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       pkt_end, buf_full, irq_n, stall, overrun;
    int         n_run = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    pkt_rx_fifo u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .blk_len(blk_len), .rd_en(rd_en), .rd_data(rd_data),
        .pkt_end(pkt_end), .buf_full(buf_full), .irq_n(irq_n),
        .stall(stall), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pull(input string req, input logic [7:0] exp);
        check(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 pkt_end", pkt_end, 0);
        check("R1 buf_full", buf_full, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 stall", stall, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_short;
        blk_len = 8'd2;
        send(8'hA1);
        check("R2 no end after 1", pkt_end, 0);
        send(8'hA2);
        check("R2 pkt_end", pkt_end, 1);
        check("R2 irq_n", irq_n, 0);
        check("R2 buf_full", buf_full, 0);
        pull("R8 byte0", 8'hA1);
        check("R8 still pending", pkt_end, 1);
        pull("R8 byte1", 8'hA2);
        check("R8 end clear", pkt_end, 0);
        check("R8 irq released", irq_n, 1);
    endtask

    task automatic t_long6;
        blk_len = 8'd6;
        for (int i = 0; i < 4; i++) send(8'h10 + 8'(i));
        check("R3 buf_full", buf_full, 1);
        check("R3 no pkt_end", pkt_end, 0);
        check("R3 irq_n", irq_n, 0);
        for (int i = 0; i < 4; i++) pull("R8 long drain", 8'h10 + 8'(i));
        check("R8 full clear", buf_full, 0);
        send(8'h14);
        check("R4 no end at 5", pkt_end, 0);
        send(8'h15);
        check("R4 pkt_end", pkt_end, 1);
        check("R4 no full", buf_full, 0);
        pull("R4 rem0", 8'h14);
        pull("R4 rem1", 8'h15);
        check("R4 clear", irq_n, 1);
    endtask

    task automatic t_len8;
        blk_len = 8'd8;
        for (int i = 0; i < 4; i++) send(8'h20 + 8'(i));
        check("R5 first full", buf_full, 1);
        check("R5 first no end", pkt_end, 0);
        for (int i = 0; i < 4; i++) pull("R5 drain a", 8'h20 + 8'(i));
        for (int i = 4; i < 8; i++) send(8'h20 + 8'(i));
        check("R5 end", pkt_end, 1);
        check("R5 full", buf_full, 1);
        for (int i = 4; i < 8; i++) pull("R5 drain b", 8'h20 + 8'(i));
        check("R5 clear", irq_n, 1);
    endtask

    task automatic t_blocked_read;
        blk_len = 8'd3;
        send(8'h31);
        check("R7 rd_data zero", rd_data, 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R7 irq idle", irq_n, 1);
        send(8'h32);
        check("R7 no early end", pkt_end, 0);
        send(8'h33);
        check("R7 end at 3", pkt_end, 1);
        pull("R7 kept0", 8'h31);
        pull("R7 kept1", 8'h32);
        pull("R7 kept2", 8'h33);
    endtask

    task automatic t_hold;
        blk_len = 8'd2;
        send(8'h40);
        send(8'h41);
        check("R6 stall pending", stall, 1);
        send(8'h42);
        check("R6 stall held", stall, 1);
        pull("R6 first0", 8'h40);
        pull("R6 first1", 8'h41);
        check("R6 still stalled before move", stall, 1);
        @(negedge clk);
        check("R6 stall released", stall, 0);
        check("R6 no end yet", pkt_end, 0);
        send(8'h43);
        check("R6 end", pkt_end, 1);
        pull("R6 held byte", 8'h42);
        pull("R6 next byte", 8'h43);
    endtask

    task automatic t_len0;
        blk_len = 8'd0;
        send(8'h50);
        check("R10 end on 1", pkt_end, 1);
        pull("R10 data", 8'h50);
        check("R10 clear", pkt_end, 0);
    endtask

    task automatic t_overrun;
        blk_len = 8'd1;
        send(8'h60);
        send(8'h61);
        check("R9 no overrun yet", overrun, 0);
        send(8'h62);
        check("R9 overrun", overrun, 1);
        pull("R9 first", 8'h60);
        @(negedge clk);
        check("R9 parked enters", pkt_end, 1);
        pull("R9 kept byte", 8'h61);
        check("R9 dropped byte absent", pkt_end, 0);
        check("R9 sticky", overrun, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short();
        t_long6();
        t_len8();
        t_blocked_read();
        t_hold();
        t_len0();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule